// File: doc/BRIEF.md
# Drift-Chamber Wire Hit Recorder

This block takes one discriminated drift-chamber wire signal and turns it into time-stamped hits. The wire is sampled at a fixed bit period of 1.2 ns. The samples reach the block as one 10-bit word per clock. A beam crossing spans 11 words, which is 110 time bins.

Inside each crossing the block finds the start and end of every pulse. It records up to seven hits, each with a start bin and a width. At the end of the crossing it reports two bits for the fast track trigger: whether any hit started early in the crossing (prompt) and whether any hit started late (delayed).

A first-level accept moves the most recently finished crossing into one of four second-level buffers. The copy takes a single cycle whatever the number of hits. A second-level decision on a buffer then does one of two things:

- An accept streams out a header word followed by one 16-bit word per hit, and then frees the buffer.
- A reject frees the buffer without any output.

If all four buffers are full when a first-level accept arrives, the accept is refused and flagged. No stored data is overwritten.

Top module: `tdc_hit_recorder`

## Requirements
- R1: `bc_start_i` marks the first word of a crossing, and a crossing has 11 words. Within a word, bit 0 is the earliest sample. The time bin of sample b in word w is w*10+b, so bins run from 0 to 109.
- R2: A hit starts where the sample goes from 0 to 1, including across a word boundary (bit 9 of the previous word against bit 0 of the current one). The hit's start bin is the bin of its first high sample. Its width is the number of high samples.
- R3: A pulse still high at the end of the crossing is closed at bin 110, so its width counts to the end of the window. A level that is already high when the crossing starts makes no hit.
- R4: At most 7 hits are kept per crossing, in start order. Any further start is dropped and sets the crossing's overflow flag.
- R5: At the clock edge that samples word 10, `trig_prompt_o` is set if any kept hit starts below bin 55, and `trig_delayed_o` is set if any kept hit starts at bin 55 or later. Both hold until the next crossing ends. Both are 0 after reset, as are `busy_o` and `rd_valid_o`.
- R6: A first-level accept sampled at an edge stores the crossing that ended before that edge into the lowest-numbered free buffer. In the next cycle `l1a_ack_o` pulses and `l1a_buf_o` gives the buffer index.
- R7: `busy_o` is high while all 4 buffers are full. A first-level accept taken while all are full pulses `l1a_err_o` in the next cycle, gives no ack and overwrites nothing.
- R8: On a second-level accept, the output is a header and then one word per kept hit, in start order.
  - Header: bit 15 = 0, bits 6:5 = buffer index, bit 4 = overflow, bits 2:0 = hit count, all other bits 0.
  - Hit word: bit 15 = 1, bits 14:8 = start bin, bits 7:0 = width.
  - `rd_last_o` marks the final word.
- R9: A second-level reject frees the buffer with no output. A decision for a buffer that is not full, or one that arrives while a readout is running, is ignored.
- R10: The header appears in the cycle after the decision. The count+1 words follow one per cycle with no gap. The buffer is free from the edge that ends the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one sample word per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 10 | Sample word, bit 0 earliest |
| bc_start_i | input | 1 | First word of a crossing |
| l1a_i | input | 1 | First-level accept |
| l2_dec_i | input | 1 | Second-level decision strobe |
| l2_acc_i | input | 1 | Decision is accept (1) or reject (0) |
| l2_buf_i | input | 2 | Buffer the decision applies to |
| trig_prompt_o | output | 1 | Last crossing had a prompt hit |
| trig_delayed_o | output | 1 | Last crossing had a delayed hit |
| l1a_ack_o | output | 1 | First-level accept stored |
| l1a_buf_o | output | 2 | Buffer used by the last stored accept |
| l1a_err_o | output | 1 | First-level accept refused, all buffers full |
| busy_o | output | 1 | All buffers full |
| rd_valid_o | output | 1 | Readout word valid |
| rd_word_o | output | 16 | Readout word |
| rd_last_o | output | 1 | Final word of a readout |

## Verification
The trigger bits are due right after the edge that samples word 10, so they are checked 1 ns after that edge. The ack, error and buffer-index outputs are registered and are sampled at that same point, because the first-level accept is driven on word 10. Second-level decisions are driven on word 0. The readout runs from the next cycle to at most word 8, and a monitor collects it on falling edges. The collected words are compared with the expected frame once the crossing ends, after the buffer has been released and before the next first-level accept is applied.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  parameter int WORD_W     = 10;
  parameter int XING_WORDS = 11;
  parameter int MAX_HITS   = 7;
  parameter int N_BUF      = 4;
  parameter int WID_W      = 8;
  parameter int RD_W       = 16;

  localparam int XING_BINS = WORD_W * XING_WORDS;
  localparam int BIN_W     = $clog2(XING_BINS + 1);
  localparam int CNT_W     = $clog2(MAX_HITS + 1);
  localparam int BUF_W     = $clog2(N_BUF);
  localparam int WIDX_W    = $clog2(XING_WORDS);

  typedef struct packed {
    logic [BIN_W-1:0] le;
    logic [WID_W-1:0] width;
  } hit_t;

  typedef struct packed {
    logic                       ovf;
    logic [CNT_W-1:0]           cnt;
    hit_t [MAX_HITS-1:0]        hits;
  } evt_t;
endpackage

// File: rtl/tdc_edge_finder.sv
module tdc_edge_finder
  import tdc_pkg::*;
#(
  parameter int PROMPT_BINS = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              bc_start_i,
  output evt_t              evt_o,
  output logic              prompt_o,
  output logic              delayed_o
);
  logic [WIDX_W-1:0] widx_q, widx;
  logic              prev_q, p;
  logic [CNT_W-1:0]  cnt_q, c;
  logic              open_q, o;
  logic              ovf_q, ov;
  logic [BIN_W-1:0]  le_q [MAX_HITS];
  logic [BIN_W-1:0]  te_q [MAX_HITS];
  logic [BIN_W-1:0]  le_d [MAX_HITS];
  logic [BIN_W-1:0]  te_d [MAX_HITS];
  logic [BIN_W-1:0]  base, pos;
  evt_t              fin;
  logic              pr_d, dl_d, done;

  always_comb begin
    if (bc_start_i || widx_q == WIDX_W'(XING_WORDS - 1)) widx = '0;
    else widx = widx_q + 1'b1;
    done = (widx == WIDX_W'(XING_WORDS - 1));
    c    = (widx == '0) ? '0   : cnt_q;
    o    = (widx == '0) ? 1'b0 : open_q;
    ov   = (widx == '0) ? 1'b0 : ovf_q;
    le_d = le_q;
    te_d = te_q;
    p    = prev_q;
    base = BIN_W'(int'(widx) * WORD_W);
    pos  = base;
    // serial scan of the word, earliest sample first
    for (int b = 0; b < WORD_W; b++) begin
      pos = base + BIN_W'(b);
      if (word_i[b] && !p) begin
        if (int'(c) < MAX_HITS) begin
          le_d[c] = pos;
          c       = c + 1'b1;
          o       = 1'b1;
        end else begin
          ov = 1'b1;
        end
      end else if (!word_i[b] && p && o) begin
        te_d[c - 1'b1] = pos;
        o              = 1'b0;
      end
      p = word_i[b];
    end
  end

  always_comb begin
    logic [BIN_W-1:0] te_f;
    logic             vld;
    fin     = '0;
    fin.cnt = c;
    fin.ovf = ov;
    pr_d    = 1'b0;
    dl_d    = 1'b0;
    for (int k = 0; k < MAX_HITS; k++) begin
      vld  = (CNT_W'(k) < c);
      te_f = (o && CNT_W'(k) == c - 1'b1) ? BIN_W'(XING_BINS) : te_d[k];
      if (vld) begin
        fin.hits[k].le    = le_d[k];
        fin.hits[k].width = WID_W'(te_f - le_d[k]);
        if (int'(le_d[k]) < PROMPT_BINS) pr_d = 1'b1;
        else                             dl_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q    <= WIDX_W'(XING_WORDS - 1);
      prev_q    <= 1'b0;
      cnt_q     <= '0;
      open_q    <= 1'b0;
      ovf_q     <= 1'b0;
      evt_o     <= '0;
      prompt_o  <= 1'b0;
      delayed_o <= 1'b0;
      for (int k = 0; k < MAX_HITS; k++) begin
        le_q[k] <= '0;
        te_q[k] <= '0;
      end
    end else begin
      widx_q <= widx;
      prev_q <= p;
      cnt_q  <= c;
      open_q <= o;
      ovf_q  <= ov;
      for (int k = 0; k < MAX_HITS; k++) begin
        le_q[k] <= le_d[k];
        te_q[k] <= te_d[k];
      end
      if (done) begin
        evt_o     <= fin;
        prompt_o  <= pr_d;
        delayed_o <= dl_d;
      end
    end
  end
endmodule

// File: rtl/tdc_l2_store.sv
module tdc_l2_store
  import tdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  evt_t             evt_i,
  input  logic             free_i,
  input  logic [BUF_W-1:0] free_id_i,
  input  logic [BUF_W-1:0] rd_id_i,
  output evt_t             evt_rd_o,
  output logic [N_BUF-1:0] full_o,
  output logic             ack_o,
  output logic             err_o,
  output logic [BUF_W-1:0] id_o
);
  evt_t             bufs [N_BUF];
  logic             found;
  logic [BUF_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N_BUF - 1; i >= 0; i--) begin
      if (!full_o[i]) begin
        found = 1'b1;
        sel   = BUF_W'(i);
      end
    end
  end

  for (genvar g = 0; g < N_BUF; g++) begin : g_slot
    evt_t slot_q;
    logic full_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
        full_q <= 1'b0;
      end else if (wr_i && found && sel == BUF_W'(g)) begin
        slot_q <= evt_i;
        full_q <= 1'b1;
      end else if (free_i && free_id_i == BUF_W'(g)) begin
        full_q <= 1'b0;
      end
    end
    assign bufs[g]   = slot_q;
    assign full_o[g] = full_q;
  end

  assign evt_rd_o = bufs[rd_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      id_o  <= '0;
    end else begin
      ack_o <= wr_i && found;
      err_o <= wr_i && !found;
      if (wr_i && found) id_o <= sel;
    end
  end
endmodule

// File: rtl/tdc_readout.sv
module tdc_readout
  import tdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             acc_i,
  input  logic [BUF_W-1:0] dec_id_i,
  input  logic [N_BUF-1:0] full_i,
  input  evt_t             evt_i,
  output logic [BUF_W-1:0] rd_id_o,
  output logic             free_o,
  output logic [BUF_W-1:0] free_id_o,
  output logic             valid_o,
  output logic [RD_W-1:0]  word_o,
  output logic             last_o
);
  logic             active_q;
  logic [BUF_W-1:0] id_q;
  logic [CNT_W-1:0] ptr_q;
  logic             start;
  hit_t             h;

  assign start     = dec_i && !active_q && full_i[dec_id_i];
  assign rd_id_o   = id_q;
  assign valid_o   = active_q;
  assign last_o    = active_q && (ptr_q == evt_i.cnt);
  assign free_o    = last_o || (start && !acc_i);
  assign free_id_o = active_q ? id_q : dec_id_i;

  always_comb begin
    h      = evt_i.hits[ptr_q - 1'b1];
    word_o = '0;
    if (ptr_q == '0) begin
      word_o[CNT_W-1:0] = evt_i.cnt;
      word_o[4]         = evt_i.ovf;
      word_o[6:5]       = id_q;
    end else begin
      word_o = {1'b1, h.le, h.width};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      id_q     <= '0;
      ptr_q    <= '0;
    end else if (start && acc_i) begin
      active_q <= 1'b1;
      id_q     <= dec_id_i;
      ptr_q    <= '0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        ptr_q    <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_hit_recorder.sv
module tdc_hit_recorder
  import tdc_pkg::*;
#(
  parameter int PROMPT_BINS = 55
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  word_i,
  input  logic        bc_start_i,
  input  logic        l1a_i,
  input  logic        l2_dec_i,
  input  logic        l2_acc_i,
  input  logic [1:0]  l2_buf_i,
  output logic        trig_prompt_o,
  output logic        trig_delayed_o,
  output logic        l1a_ack_o,
  output logic [1:0]  l1a_buf_o,
  output logic        l1a_err_o,
  output logic        busy_o,
  output logic        rd_valid_o,
  output logic [15:0] rd_word_o,
  output logic        rd_last_o
);
  evt_t             cap, rd_evt;
  logic [N_BUF-1:0] full;
  logic             free;
  logic [BUF_W-1:0] free_id, rd_id;

  tdc_edge_finder #(.PROMPT_BINS(PROMPT_BINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word_i),
    .bc_start_i(bc_start_i),
    .evt_o     (cap),
    .prompt_o  (trig_prompt_o),
    .delayed_o (trig_delayed_o)
  );

  tdc_l2_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (l1a_i),
    .evt_i    (cap),
    .free_i   (free),
    .free_id_i(free_id),
    .rd_id_i  (rd_id),
    .evt_rd_o (rd_evt),
    .full_o   (full),
    .ack_o    (l1a_ack_o),
    .err_o    (l1a_err_o),
    .id_o     (l1a_buf_o)
  );

  tdc_readout u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_i    (l2_dec_i),
    .acc_i    (l2_acc_i),
    .dec_id_i (l2_buf_i),
    .full_i   (full),
    .evt_i    (rd_evt),
    .rd_id_o  (rd_id),
    .free_o   (free),
    .free_id_o(free_id),
    .valid_o  (rd_valid_o),
    .word_o   (rd_word_o),
    .last_o   (rd_last_o)
  );

  assign busy_o = &full;
endmodule

// File: rtl/tdc_hit_recorder_chk.sv
module tdc_hit_recorder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        l1a_ack_o,
  input logic        l1a_err_o,
  input logic        busy_o,
  input logic        rd_valid_o,
  input logic [15:0] rd_word_o,
  input logic        rd_last_o
);
  assert_ack_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l1a_ack_o && l1a_err_o));

  assert_err_only_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1a_err_o |-> $past(busy_o));

  assert_ack_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1a_ack_o |-> !$past(busy_o));

  assert_last_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  assert_frame_contig_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last_o) |=> rd_valid_o);

  assert_header_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> !rd_word_o[15]);

  assert_hit_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_word_o[15]) |-> (rd_word_o[14:8] < 7'd110 && rd_word_o[7:0] != 8'd0));
endmodule

bind tdc_hit_recorder tdc_hit_recorder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .l1a_ack_o (l1a_ack_o),
  .l1a_err_o (l1a_err_o),
  .busy_o    (busy_o),
  .rd_valid_o(rd_valid_o),
  .rd_word_o (rd_word_o),
  .rd_last_o (rd_last_o)
);

// File: tb/sim_tdc_hit_recorder.sv
module sim_tdc_hit_recorder;
  localparam int PB = 55;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  word_i = '0;
  logic        bc_start_i = 1'b0, l1a_i = 1'b0, l2_dec_i = 1'b0, l2_acc_i = 1'b0;
  logic [1:0]  l2_buf_i = '0;
  logic        trig_prompt_o, trig_delayed_o, l1a_ack_o, l1a_err_o, busy_o;
  logic        rd_valid_o, rd_last_o;
  logic [1:0]  l1a_buf_o;
  logic [15:0] rd_word_o;

  tdc_hit_recorder u0 (.*);

  always #5 clk_i = ~clk_i;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit          m_prev = 0;
  int          cap_n = 0;
  logic [15:0] cap_w [8];
  bit          mb_full [4];
  logic [15:0] mb_w [4][8];
  int          mb_len [4];
  int          x_n; bit x_ovf, x_pr, x_dl;
  int          x_le [7], x_wd [7];
  logic [15:0] exp_rd [8];
  int          exp_n;
  logic [15:0] got [16];
  bit          got_last [16];
  int          got_n = 0;

  always @(negedge clk_i) if (rd_valid_o && got_n < 16) begin
    got[got_n] = rd_word_o; got_last[got_n] = rd_last_o; got_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference scan of one crossing, bin by bin
  task automatic model_xing(input logic [109:0] bits);
    bit p = m_prev, rec = 0;
    x_n = 0; x_ovf = 0; x_pr = 0; x_dl = 0;
    for (int i = 0; i < 110; i++) begin
      if (bits[i] && !p) begin
        if (x_n < 7) begin x_le[x_n] = i; x_wd[x_n] = 0; x_n++; rec = 1; end
        else begin x_ovf = 1; rec = 0; end
      end
      if (!bits[i]) rec = 0;
      if (bits[i] && rec) x_wd[x_n-1]++;
      p = bits[i];
    end
    m_prev = p;
    for (int k = 0; k < x_n; k++) begin
      if (x_le[k] < PB) x_pr = 1; else x_dl = 1;
    end
  endtask

  task automatic run_xing(input logic [109:0] bits, input bit l1a, input bit dec,
                          input bit acc, input int did);
    int  sel = -1;
    bit  exp_busy;
    exp_n = 0;
    got_n = 0;
    if (dec && mb_full[did]) begin
      if (acc) begin
        exp_n = mb_len[did];
        for (int k = 0; k < exp_n; k++) exp_rd[k] = mb_w[did][k];
      end
      mb_full[did] = 0;
    end
    if (l1a) begin
      for (int b = 3; b >= 0; b--) if (!mb_full[b]) sel = b;
      if (sel >= 0) begin
        mb_full[sel] = 1;
        mb_len[sel]  = cap_n;
        for (int k = 0; k < cap_n; k++) mb_w[sel][k] = cap_w[k];
        mb_w[sel][0][6:5] = 2'(sel);
      end
    end
    model_xing(bits);
    cap_n = x_n + 1;
    cap_w[0] = 16'(x_ovf) << 4 | 16'(x_n);
    for (int k = 0; k < x_n; k++) cap_w[k+1] = {1'b1, 7'(x_le[k]), 8'(x_wd[k])};
    exp_busy = mb_full[0] && mb_full[1] && mb_full[2] && mb_full[3];

    for (int w = 0; w < 11; w++) begin
      @(negedge clk_i);
      word_i     = bits[w*10 +: 10];
      bc_start_i = (w == 0);
      l2_dec_i   = dec && (w == 0);
      l2_acc_i   = acc;
      l2_buf_i   = 2'(did);
      l1a_i      = l1a && (w == 10);
    end
    @(posedge clk_i); #1;

    chk(trig_prompt_o == x_pr, "R5 prompt", trig_prompt_o, x_pr);
    chk(trig_delayed_o == x_dl, "R5 delayed", trig_delayed_o, x_dl);
    chk(busy_o == exp_busy, "R7 busy", busy_o, exp_busy);
    if (l1a) begin
      if (sel >= 0) begin
        chk(l1a_ack_o && !l1a_err_o, "R6 ack", {l1a_ack_o, l1a_err_o}, 2);
        chk(l1a_buf_o == 2'(sel), "R6 buffer index", l1a_buf_o, sel);
      end else begin
        chk(l1a_err_o && !l1a_ack_o, "R7 refused accept", {l1a_ack_o, l1a_err_o}, 1);
      end
    end else begin
      chk(!l1a_ack_o && !l1a_err_o, "R6 no accept", {l1a_ack_o, l1a_err_o}, 0);
    end
    // R8 R9 R10: frame content, length and last marker
    chk(got_n == exp_n, "R9 R10 readout length", got_n, exp_n);
    if (got_n == exp_n) begin
      for (int k = 0; k < exp_n; k++) begin
        chk(got[k] == exp_rd[k], "R8 readout word", got[k], exp_rd[k]);
        chk(got_last[k] == (k == exp_n - 1), "R8 last flag", got_last[k], k == exp_n - 1);
      end
    end
  endtask

  function automatic logic [109:0] pulses(input int start, input int len);
    logic [109:0] v = '0;
    for (int i = start; i < start + len && i < 110; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [109:0] rnd_bits(input int rate);
    logic [109:0] v;
    bit lvl = 0;
    for (int i = 0; i < 110; i++) begin
      if ($urandom_range(rate - 1) == 0) lvl = !lvl;
      v[i] = lvl;
    end
    return v;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [109:0] v;
    void'($urandom(32'd20040720));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(!trig_prompt_o && !trig_delayed_o && !busy_o && !rd_valid_o, "R5 reset state",
        {trig_prompt_o, trig_delayed_o, busy_o, rd_valid_o}, 0);

    // R1 R2: hit starting on a word boundary, one ending on a boundary
    run_xing(pulses(10, 10) | pulses(70, 5), 0, 0, 0, 0);
    run_xing('0, 1, 0, 0, 0);
    run_xing('0, 0, 1, 1, 0);
    // R4: nine pulses, seven kept
    v = '0;
    for (int i = 0; i < 9; i++) v |= pulses(i * 12, 2);
    run_xing(v, 0, 0, 0, 0);
    // R3: pulse open at the end, then carried into next crossing
    run_xing(pulses(100, 10), 1, 0, 0, 0);
    run_xing(pulses(0, 5) | pulses(30, 2), 1, 0, 0, 0);
    run_xing('0, 1, 1, 1, 0);
    run_xing('0, 0, 1, 1, 1);
    run_xing('0, 0, 1, 1, 2);
    // R7: fill all buffers, then one more accept
    run_xing(pulses(3, 4), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) run_xing(pulses(60 + i, 3), 1, 0, 0, 0);
    run_xing('0, 1, 0, 0, 0);
    // R9: reject frees buffer 2, reused by the accept in the same crossing
    run_xing('0, 1, 1, 0, 2);
    for (int i = 0; i < 4; i++) run_xing('0, 0, 1, 1, i);
    // R9: accept for an empty buffer gives nothing
    run_xing('0, 0, 1, 1, 1);

    for (int n = 0; n < 200; n++) begin
      run_xing(rnd_bits((n % 3 == 0) ? 3 : 10), $urandom_range(1) == 1,
               $urandom_range(1) == 1, $urandom_range(3) != 0, int'($urandom_range(3)));
    end

    @(negedge clk_i);
    l1a_i = 0; l2_dec_i = 0; bc_start_i = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule